// File: doc/BRIEF.md
# Host-Clocked Received-Byte Buffer

This block sits behind an asynchronous word receiver that has already removed the start and stop bits. Each time the receiver reports a complete 8-bit word while the carrier is judged valid, the byte is loaded in parallel into a one-byte shift register. An active-low ready line then drops to tell the host that a byte is waiting.

The host reads the byte over three wires. It drives a read clock into the block, and each rising edge of that clock puts the next bit on the serial data output, starting with the bit that was received first. The read clock is asynchronous to the system clock. It passes through a synchroniser, and its rising edges are detected in the system clock domain.

The ready line returns high on the first read edge. If no read edge arrives, it returns high after half a nominal bit time. Read edges beyond the eighth are ignored.

Two small state machines make up the control. The ready machine has the states `RDY_IDLE` (line high) and `RDY_WAIT` (line low, timer running):
- `RDY_IDLE` moves to `RDY_WAIT` when a byte loads.
- `RDY_WAIT` moves back to `RDY_IDLE` on a read edge or when the timer expires.
- A load during `RDY_WAIT` keeps the machine in `RDY_WAIT` and restarts the timer.

The shifter machine has the states `SH_EMPTY` (no unread bits) and `SH_HOLD` (bits pending):
- `SH_EMPTY` moves to `SH_HOLD` on a load.
- `SH_HOLD` moves back to `SH_EMPTY` after the eighth shift.
- A load during `SH_HOLD` restarts the bit count.

Top module: `hb_byte_buffer`

## Requirements
- R1: After reset `rdy_n` is 1 and `sdata` is 1. Read clock edges before any byte has loaded leave `sdata` at 1.
- R2: A cycle with `word_valid`=1 and `carrier_ok`=1 loads `word_data`. `rdy_n` is 0 from the next clock edge on.
- R3: A cycle with `word_valid`=1 and `carrier_ok`=0 loads nothing. `rdy_n` stays as it was, and the bits still held for reading are unchanged.
- R4: Each rising edge of `host_sclk` places the next stored bit on `sdata`, in the order `word_data[0]` first to `word_data[7]` last. `sdata` changes three system clock cycles after the edge, after two synchroniser stages and one edge-detect stage. `sdata` changes at no other time.
- R5: A read clock rising edge seen while `rdy_n` is 0 returns `rdy_n` to 1.
- R6: With no read edge, `rdy_n` stays 0 for exactly `HALF_BIT_CYCLES` system clock cycles after a load, then returns to 1.
- R7: After the eighth bit has been shifted out, further read clock edges leave `sdata` unchanged.
- R8: A new load overwrites the held byte even when it is only partly read. The next read edge then yields bit 0 of the new byte, and the `rdy_n` low-time timer restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_ok | input | 1 | Carrier valid qualifier from the receiver |
| word_valid | input | 1 | One-cycle strobe: a framed word has been received |
| word_data | input | DATA_W | Received data bits, bit 0 received first |
| host_sclk | input | 1 | Host read clock, asynchronous |
| sdata | output | 1 | Serial data to the host |
| rdy_n | output | 1 | Active-low byte-ready indication |

## Verification
On every cycle, the bound checker confirms four things:
- a qualified load always drives `rdy_n` low;
- an unqualified word never does;
- a detected read edge always clears a pending ready;
- `sdata` never moves without a detected read edge.

A cycle counter in the checker also bounds the low time of `rdy_n` by `HALF_BIT_CYCLES`.

Only the bench scenarios can show the remaining behaviour, such as the bit order, the exact low time after a timeout, and ignored excess edges. They also cover a byte overwritten mid-read with the timer restarted, and a blocked load that leaves the previous byte intact.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        RDY_IDLE = 1'b0,
        RDY_WAIT = 1'b1
    } rdy_state_t;

    typedef enum logic {
        SH_EMPTY = 1'b0,
        SH_HOLD  = 1'b1
    } sh_state_t;

endpackage

// File: rtl/hb_sclk_sync.sv
module hb_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_async,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b0;
                end else if (i == 0) begin
                    chain_q[i] <= sclk_async;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/hb_shifter.sv
module hb_shifter
    import hb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    output logic              sdata
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    sh_state_t         state_q, state_d;
    logic [DATA_W-1:0] bits_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sdata_q;
    logic              do_shift;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_EMPTY: if (load) state_d = SH_HOLD;
            SH_HOLD: begin
                if (load)                                state_d = SH_HOLD;
                else if (shift_en && cnt_q == LAST_BIT)  state_d = SH_EMPTY;
            end
            default: state_d = SH_EMPTY;
        endcase
    end

    assign do_shift = shift_en && !load && (state_q == SH_HOLD);

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q  <= '0;
            cnt_q   <= '0;
            sdata_q <= 1'b1;
        end else if (load) begin
            bits_q <= load_data;
            cnt_q  <= '0;
        end else if (do_shift) begin
            sdata_q <= bits_q[0];
            bits_q  <= {1'b0, bits_q[DATA_W-1:1]};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        sdata = sdata_q;
    end

endmodule

// File: rtl/hb_ready_fsm.sv
module hb_ready_fsm
    import hb_pkg::*;
#(
    parameter int HALF_BIT_CYCLES = 41667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rd_rise,
    output logic rdy_n
);
    localparam int TMR_W = $clog2(HALF_BIT_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(HALF_BIT_CYCLES - 1);

    rdy_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RDY_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RDY_IDLE: if (load) state_d = RDY_WAIT;
            RDY_WAIT: begin
                if (load)                   state_d = RDY_WAIT;
                else if (rd_rise)           state_d = RDY_IDLE;
                else if (tmr_q == TMR_LAST) state_d = RDY_IDLE;
            end
            default: state_d = RDY_IDLE;
        endcase
    end

    // Low-time timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   tmr_q <= '0;
        else if (load)                tmr_q <= '0;
        else if (state_q == RDY_WAIT) tmr_q <= tmr_q + 1'b1;
    end

    // Outputs
    always_comb begin
        rdy_n = (state_q != RDY_WAIT);
    end

endmodule

// File: rtl/hb_byte_buffer.sv
module hb_byte_buffer #(
    parameter int DATA_W          = 8,
    parameter int HALF_BIT_CYCLES = 41667,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_ok,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              host_sclk,
    output logic              sdata,
    output logic              rdy_n
);
    logic load;
    logic rd_rise;

    assign load = word_valid & carrier_ok;

    hb_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_async (host_sclk),
        .rise       (rd_rise)
    );

    hb_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (word_data),
        .shift_en  (rd_rise),
        .sdata     (sdata)
    );

    hb_ready_fsm #(.HALF_BIT_CYCLES(HALF_BIT_CYCLES)) u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .rd_rise (rd_rise),
        .rdy_n   (rdy_n)
    );

endmodule

// File: rtl/hb_byte_buffer_chk.sv
module hb_byte_buffer_chk #(
    parameter int HALF_BIT_CYCLES = 41667
) (
    input logic clk,
    input logic rst_n,
    input logic carrier_ok,
    input logic word_valid,
    input logic rd_rise,
    input logic sdata,
    input logic rdy_n
);
    logic [31:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      low_cnt <= '0;
        else if (word_valid && carrier_ok) low_cnt <= '0;
        else if (!rdy_n)                 low_cnt <= low_cnt + 1;
        else                             low_cnt <= '0;
    end

    p_load_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && carrier_ok) |=> !rdy_n);

    p_no_load_without_carrier_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !carrier_ok && rdy_n) |=> rdy_n);

    p_sdata_moves_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $past(rd_rise));

    p_read_clears_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && rd_rise && !(word_valid && carrier_ok)) |=> rdy_n);

    p_ready_low_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> (low_cnt < 32'(HALF_BIT_CYCLES)));

endmodule

bind hb_byte_buffer hb_byte_buffer_chk #(.HALF_BIT_CYCLES(HALF_BIT_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_ok (carrier_ok),
    .word_valid (word_valid),
    .rd_rise    (rd_rise),
    .sdata      (sdata),
    .rdy_n      (rdy_n)
);

// File: tb/hb_byte_buffer_test.sv
`timescale 1ns/1ps
module hb_byte_buffer_test;
    localparam int HALF = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier_ok = 1'b1;
    logic       word_valid = 1'b0;
    logic [7:0] word_data = 8'h00;
    logic       host_sclk = 1'b0;
    logic       sdata;
    logic       rdy_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic  exp_q[$];
    string tag_q[$];
    logic  last_exp = 1'b1;
    event  sample_ev;

    always #5 clk = ~clk;

    hb_byte_buffer #(.DATA_W(8), .HALF_BIT_CYCLES(HALF), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .word_valid(word_valid),
        .word_data(word_data), .host_sclk(host_sclk), .sdata(sdata), .rdy_n(rdy_n)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver side: push expected serial bits
    task automatic expect_bits(input logic [7:0] b, input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) begin
            exp_q.push_back(b[i]);
            tag_q.push_back(tag);
            last_exp = b[i];
        end
    endtask

    task automatic expect_hold(input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) begin
            exp_q.push_back(last_exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic read_one();
        host_sclk = 1'b1;
        repeat (6) @(negedge clk);
        -> sample_ev;
        host_sclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_n(input int cnt);
        for (int i = 0; i < cnt; i++) read_one();
    endtask

    task automatic load_byte(input logic [7:0] b, input logic car);
        @(negedge clk);
        word_data  = b;
        carrier_ok = car;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        carrier_ok = 1'b1;
    endtask

    // Monitor: compare each read result against the queue
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "monitor queue empty", int'(sdata), -1);
            end else begin
                automatic logic  e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(sdata === e, t, int'(sdata), int'(e));
            end
        end
    end

    initial begin
        #2_000_000;
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lowc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy_n === 1'b1, "R1 rdy_n after reset", int'(rdy_n), 1);
        check(sdata === 1'b1, "R1 sdata after reset", int'(sdata), 1);
        expect_hold(2, "R1 reads with nothing loaded");
        read_n(2);

        // R2 then R6: load with no reads, measure low time
        load_byte(8'hA5, 1'b1);
        check(rdy_n === 1'b0, "R2 rdy_n after load", int'(rdy_n), 0);
        lowc = 0;
        while (!rdy_n && lowc < 1000) begin
            lowc++;
            @(negedge clk);
        end
        check(lowc == HALF, "R6 rdy_n low cycles", lowc, HALF);

        // R4 bit order, then R7 excess edges
        expect_bits(8'hA5, 8, "R4 order of 0xA5");
        read_n(8);
        expect_hold(3, "R7 excess reads");
        read_n(3);

        // R5: first read clears ready
        load_byte(8'h3C, 1'b1);
        check(rdy_n === 1'b0, "R2 rdy_n low before read", int'(rdy_n), 0);
        expect_bits(8'h3C, 8, "R4 order of 0x3C");
        read_one();
        check(rdy_n === 1'b1, "R5 rdy_n cleared by first read", int'(rdy_n), 1);
        read_n(7);

        // R3: blocked load leaves state untouched
        load_byte(8'hFF, 1'b0);
        repeat (3) @(negedge clk);
        check(rdy_n === 1'b1, "R3 rdy_n with carrier low", int'(rdy_n), 1);
        expect_hold(2, "R3 no load without carrier");
        read_n(2);

        // R8: overwrite during a partial read
        load_byte(8'h0F, 1'b1);
        expect_bits(8'h0F, 3, "R8 partial read of 0x0F");
        read_n(3);
        load_byte(8'hB2, 1'b1);
        check(rdy_n === 1'b0, "R8 rdy_n after overwrite", int'(rdy_n), 0);
        expect_bits(8'hB2, 8, "R8 order of 0xB2 after overwrite");
        read_n(8);

        // R8: timer restart on reload
        load_byte(8'h11, 1'b1);
        repeat (30) @(negedge clk);
        load_byte(8'h55, 1'b1);
        repeat (30) @(negedge clk);
        check(rdy_n === 1'b0, "R8 timer restarted by reload", int'(rdy_n), 0);
        expect_bits(8'h55, 8, "R4 order of 0x55");
        read_n(8);
        check(exp_q.size() == 0, "R4 all expected bits consumed", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule